// File: doc/BRIEF.md
# Crystal Oscillator Chirp-Injection Startup Sequencer

This controller shortens crystal oscillator startup by steering an auxiliary injection oscillator through a downward frequency sweep. It drives that oscillator's digital frequency code, an enable for the injection driver, a select for the driver's strong setting, and an enable that passes the crystal to the main sustaining driver. Its only analog-facing input is one comparator bit. That bit goes high when the crystal's voltage envelope sags, which happens as the injected tone nears resonance.

After a start request the code begins at a programmed upper value and the driver runs at weak strength. The code steps down by one every N clock cycles. A comparator indication must survive a two-flop synchronizer and then stay high for a programmed number of consecutive cycles. When it does, the code freezes and is reported as the locked code, and the driver switches to strong injection for a programmed number of cycles. Injection then stops and the main driver takes over.

If the sweep dwells a full step period at the lower limit without a detection, a timeout flag is raised and the controller hands over without boosting. Normal self-starting still follows in that case.

Top module: `xo_chirp_seq`

## Requirements
- R1: While rst_n is low, and on the cycle after any edge with en low, inj_en, drive_hi, hold, main_en, timeout and done_pulse are 0 and freq_code equals code_hi. Reset also clears lock_code to 0.
- R2: A start sampled high while the block is idle or done begins the search on the next cycle. In that cycle inj_en=1, drive_hi=0 and freq_code=code_hi. A start sampled during search, boost or handover is ignored.
- R3: During search, freq_code drops by exactly 1 at the end of every N-th search cycle, where N is step_div and 0 counts as 1. It never goes below code_lo.
- R4: cmp_in passes through two synchronizing flops. A detection is taken at the end of the Q-th consecutive cycle in which the synchronized value is 1, where Q is qual_len and 0 counts as 1. Shorter high runs have no effect on the sweep.
- R5: On detection, hold becomes 1 and stays 1 until the next start or abort. freq_code freezes, and lock_code takes the frozen value. drive_hi is 1 with inj_en for exactly boost_len cycles, where 0 counts as 1.
- R6: Boost is followed by one handover cycle with inj_en=0 and main_en=1, then the done state. main_en stays 1 in the done state.
- R7: If a step tick occurs while freq_code equals code_lo and there is no detection, timeout becomes 1. The block goes directly to handover with drive_hi never set and hold left 0. lock_code becomes code_lo.
- R8: done_pulse is 1 for exactly one cycle, the first cycle of the done state.
- R9: Deasserting en mid-sequence returns the block to idle on the next edge, with the outputs given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low forces idle |
| start | input | 1 | Start request |
| cmp_in | input | 1 | Asynchronous envelope-droop comparator bit |
| code_hi | input | CW | Sweep start code (upper limit) |
| code_lo | input | CW | Sweep floor code (lower limit) |
| step_div | input | DW | Cycles per code step |
| qual_len | input | QW | Consecutive synchronized cycles needed for detection |
| boost_len | input | BW | Strong-injection duration in cycles |
| freq_code | output | CW | Injection oscillator frequency code |
| inj_en | output | 1 | Injection driver enable |
| drive_hi | output | 1 | Injection driver strong setting |
| hold | output | 1 | Frequency code frozen by detection |
| main_en | output | 1 | Main sustaining driver enable |
| timeout | output | 1 | Sweep reached floor without detection |
| done_pulse | output | 1 | One-cycle pulse on entering done |
| lock_code | output | CW | Code captured at detection or timeout |

## Verification
With resonance at code R, the search lasts (code_hi-R)*N + Q + 2 cycles. That is the time for the code to reach R, plus two synchronizer stages, plus Q qualifying cycles. Boost adds boost_len cycles, handover adds one, and done_pulse appears on the following cycle. A timed-out run has (code_hi-code_lo+1)*N search cycles and no boost. The bench computes these values before each start and queues them. A monitor sampling at falling edges counts inj_en and drive_hi cycles and compares the totals, the locked code and the flags at the cycle where done_pulse shows. Point checks are taken on a fixed number of falling edges after the start or abort stimulus: the code on a given search cycle, the outputs one cycle after en drops, and done_pulse one cycle after it shows.

// File: rtl/xo_chirp_pkg.sv
// Shared types for the chirp-injection startup sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package xo_chirp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SEARCH   = 3'd1,
        ST_BOOST    = 3'd2,
        ST_HANDOVER = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/xo_sync.sv
// Multi-stage synchronizer for a single asynchronous bit.
// Assumes: the input is a level that is held for more than one clock period.
module xo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop variant.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            // Shift chain of flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];

endmodule

// File: rtl/xo_droop_qual.sv
// Qualifies the synchronized droop bit: flags a detection on the Q-th
// consecutive high cycle while armed.
// Assumes: qual_len of 0 is treated as 1.
module xo_droop_qual #(
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          arm,
    input  logic          cmp_s,
    input  logic [QW-1:0] qual_len,
    output logic          det
);

    logic [QW-1:0] run_cnt;
    logic [QW-1:0] qlen_eff;

    assign qlen_eff = (qual_len == '0) ? QW'(1) : qual_len;
    assign det      = arm && cmp_s && (run_cnt == qlen_eff - QW'(1));

    // Count consecutive armed high cycles; restart on any low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            run_cnt <= '0;
        else if (arm && cmp_s && !det) run_cnt <= run_cnt + QW'(1);
        else                          run_cnt <= '0;
    end

endmodule

// File: rtl/xo_code_sweep.sv
// Frequency code register and step-rate divider for the downward sweep.
// Assumes: step_div of 0 is treated as 1; code_lo <= code_hi for a real sweep.
module xo_code_sweep #(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] code_hi,
    input  logic [CW-1:0] code_lo,
    input  logic [DW-1:0] step_div,
    output logic [CW-1:0] code,
    output logic          tick,
    output logic          at_floor
);

    logic [DW-1:0] div_cnt;
    logic [DW-1:0] div_eff;

    assign div_eff  = (step_div == '0) ? DW'(1) : step_div;
    assign tick     = run && (div_cnt == div_eff - DW'(1));
    assign at_floor = (code <= code_lo);

    // Load the start code, or step down once per divider period while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            code    <= code_hi;
            div_cnt <= '0;
        end else if (run) begin
            if (tick) begin
                div_cnt <= '0;
                if (!at_floor) code <= code - CW'(1);
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    // The code never steps below the floor while sweeping.
    assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(code_lo) && ($past(code) >= code_lo))
        |-> (code >= code_lo));

endmodule

// File: rtl/xo_chirp_fsm.sv
// Sequencing state machine: idle, search, boost, handover, done.
// Assumes: det and tick come from the qualifier and sweep of the same clock.
module xo_chirp_fsm
    import xo_chirp_pkg::*;
#(
    parameter int CW = 8,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          det,
    input  logic          tick,
    input  logic          at_floor,
    input  logic [CW-1:0] code,
    input  logic [BW-1:0] boost_len,
    output logic          sweep_load,
    output logic          sweep_run,
    output logic          qual_arm,
    output logic          inj_en,
    output logic          drive_hi,
    output logic          main_en,
    output logic          hold,
    output logic          timeout,
    output logic          done_pulse,
    output logic [CW-1:0] lock_code
);

    seq_state_t    state, nxt;
    logic [BW-1:0] bcnt;
    logic [BW-1:0] blen_eff;
    logic          go;
    logic          tmo;
    logic          boost_end;

    assign blen_eff   = (boost_len == '0) ? BW'(1) : boost_len;
    assign go         = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign tmo        = (state == ST_SEARCH) && !det && tick && at_floor;
    assign boost_end  = (state == ST_BOOST) && (bcnt == blen_eff - BW'(1));

    assign qual_arm   = (state == ST_SEARCH);
    assign sweep_run  = (state == ST_SEARCH) && !det;
    assign sweep_load = (state == ST_IDLE) || go;

    assign inj_en     = (state == ST_SEARCH) || (state == ST_BOOST);
    assign drive_hi   = (state == ST_BOOST);
    assign main_en    = (state == ST_HANDOVER) || (state == ST_DONE);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (go) nxt = ST_SEARCH;
            ST_SEARCH:   if (det) nxt = ST_BOOST;
                         else if (tmo) nxt = ST_HANDOVER;
            ST_BOOST:    if (boost_end) nxt = ST_HANDOVER;
            ST_HANDOVER: nxt = ST_DONE;
            ST_DONE:     if (go) nxt = ST_SEARCH;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset and enable abort.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) state <= ST_IDLE;
        else               state <= nxt;
    end

    // Boost duration counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || det || state != ST_BOOST) bcnt <= '0;
        else                                         bcnt <= bcnt + BW'(1);
    end

    // Hold, timeout and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold       <= 1'b0;
            timeout    <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= (state == ST_HANDOVER);
            if (go) begin
                hold    <= 1'b0;
                timeout <= 1'b0;
            end else begin
                if (det) hold    <= 1'b1;
                if (tmo) timeout <= 1'b1;
            end
        end
    end

    // Capture the frozen code on detection or the floor code on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)          lock_code <= '0;
        else if (det || tmo) lock_code <= code;
    end

    // The done pulse lasts exactly one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // The main driver is only enabled straight after injection.
    assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> $past(inj_en));

endmodule

// File: rtl/xo_chirp_seq.sv
// Top of the chirp-injection startup sequencer: synchronizes the droop
// comparator, qualifies it, sweeps the code and sequences the drivers.
// Assumes: configuration inputs are static while a sequence runs.
module xo_chirp_seq #(
    parameter int CW    = 8,
    parameter int DW    = 8,
    parameter int QW    = 4,
    parameter int BW    = 8,
    parameter int SYNCS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          cmp_in,
    input  logic [CW-1:0] code_hi,
    input  logic [CW-1:0] code_lo,
    input  logic [DW-1:0] step_div,
    input  logic [QW-1:0] qual_len,
    input  logic [BW-1:0] boost_len,
    output logic [CW-1:0] freq_code,
    output logic          inj_en,
    output logic          drive_hi,
    output logic          hold,
    output logic          main_en,
    output logic          timeout,
    output logic          done_pulse,
    output logic [CW-1:0] lock_code
);

    logic cmp_s;
    logic det;
    logic tick;
    logic at_floor;
    logic sweep_load;
    logic sweep_run;
    logic qual_arm;

    xo_sync #(.STAGES(SYNCS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    xo_droop_qual #(.QW(QW)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .arm      (qual_arm),
        .cmp_s    (cmp_s),
        .qual_len (qual_len),
        .det      (det)
    );

    xo_code_sweep #(.CW(CW), .DW(DW)) i_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .load     (sweep_load),
        .run      (sweep_run),
        .code_hi  (code_hi),
        .code_lo  (code_lo),
        .step_div (step_div),
        .code     (freq_code),
        .tick     (tick),
        .at_floor (at_floor)
    );

    xo_chirp_fsm #(.CW(CW), .BW(BW)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .start      (start),
        .det        (det),
        .tick       (tick),
        .at_floor   (at_floor),
        .code       (freq_code),
        .boost_len  (boost_len),
        .sweep_load (sweep_load),
        .sweep_run  (sweep_run),
        .qual_arm   (qual_arm),
        .inj_en     (inj_en),
        .drive_hi   (drive_hi),
        .main_en    (main_en),
        .hold       (hold),
        .timeout    (timeout),
        .done_pulse (done_pulse),
        .lock_code  (lock_code)
    );

    // The code does not move while it is held.
    assert_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(freq_code));

    // Hold is only taken on a synchronized droop.
    assert_hold_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(cmp_s));

    // Dropping the enable shuts off every driver on the next edge.
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!inj_en && !main_en && !hold));

endmodule

// File: tb/test_xo_chirp_seq.sv
// Scoreboard bench for the chirp-injection startup sequencer.
module test_xo_chirp_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       start = 1'b0;
    logic       cmp_in;
    logic [7:0] code_hi = 8'd40, code_lo = 8'd20, step_div = 8'd6;
    logic [3:0] qual_len = 4'd3;
    logic [7:0] boost_len = 8'd10;
    logic [7:0] freq_code, lock_code;
    logic       inj_en, drive_hi, hold, main_en, timeout, done_pulse;

    logic [7:0] res_code = 8'd0;
    logic       glitch = 1'b0;
    int         nvec = 0, nbad = 0;

    typedef struct {
        logic [7:0] lock;
        logic       to;
        logic       hd;
        int         inj;
        int         bst;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    // Crystal envelope model: droops only when injecting at resonance.
    assign cmp_in = (inj_en && (freq_code == res_code)) || glitch;

    xo_chirp_seq i_xo_chirp_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cmp_in(cmp_in),
        .code_hi(code_hi), .code_lo(code_lo), .step_div(step_div),
        .qual_len(qual_len), .boost_len(boost_len),
        .freq_code(freq_code), .inj_en(inj_en), .drive_hi(drive_hi),
        .hold(hold), .main_en(main_en), .timeout(timeout),
        .done_pulse(done_pulse), .lock_code(lock_code)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        nvec++;
        if (act != exp_v) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    // Monitor: counts injection cycles and compares with the scoreboard at done.
    int inj_cnt = 0, bst_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!inj_en && !main_en) begin
                inj_cnt = 0;
                bst_cnt = 0;
            end
            if (inj_en)   inj_cnt++;
            if (drive_hi) bst_cnt++;
            if (done_pulse) begin
                if (sb.size() == 0) begin
                    chk("R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R5/R7 lock_code", int'(lock_code), int'(e.lock));
                    chk("R7 timeout", int'(timeout), int'(e.to));
                    chk("R5 hold", int'(hold), int'(e.hd));
                    chk("R4 injection cycles", inj_cnt, e.inj);
                    chk("R5 boost cycles", bst_cnt, e.bst);
                    chk("R6 main_en at done", int'(main_en), 1);
                end
                inj_cnt = 0;
                bst_cnt = 0;
            end
        end
    end

    // Driver: configure, predict, start, apply side stimulus, wait for done.
    task automatic run_case(input int h, input int l, input int n, input int q,
                            input int b, input int r, input int chk_j,
                            input int glitch_at, input int mid_start);
        exp_t e;
        int   beff, cyc;
        beff = (b == 0) ? 1 : b;
        @(negedge clk);
        code_hi = 8'(h); code_lo = 8'(l); step_div = 8'(n);
        qual_len = 4'(q); boost_len = 8'(b); res_code = 8'(r);
        if (r <= h && r >= l) begin
            e.lock = 8'(r); e.to = 1'b0; e.hd = 1'b1;
            e.inj = (h - r) * n + q + 2 + beff; e.bst = beff;
        end else begin
            e.lock = 8'(l); e.to = 1'b1; e.hd = 1'b0;
            e.inj = (h - l + 1) * n; e.bst = 0;
        end
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 inj_en on first search cycle", int'(inj_en), 1);
        chk("R2 drive_hi low in search", int'(drive_hi), 0);
        chk("R2 code starts at code_hi", int'(freq_code), h);
        cyc = 0;
        forever begin
            if (done_pulse) break;
            if (cyc == chk_j)
                chk("R3 code after steps", int'(freq_code), h - cyc / n);
            if (cyc == glitch_at) glitch = 1'b1;
            if (cyc == glitch_at + q - 1) glitch = 1'b0;
            start = (cyc == mid_start);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
        chk("R8 done_pulse falls", int'(done_pulse), 0);
        chk("R6 main_en held in done", int'(main_en), 1);
        chk("R6 inj_en off in done", int'(inj_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 freq_code in reset", int'(freq_code), 40);
        chk("R1 inj_en in reset", int'(inj_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 freq_code after reset", int'(freq_code), 40);
        chk("R1 drivers off after reset", int'({inj_en, drive_hi, main_en}), 0);
        chk("R1 flags clear after reset", int'({hold, timeout, done_pulse}), 0);
        chk("R1 lock_code after reset", int'(lock_code), 0);

        // Mid-range lock with an R3 step check.
        run_case(40, 20, 6, 3, 10, 35, 13, -1, -1);
        // Lock on the very first code, N = Q+2, boost_len 0 -> 1 (restart from done).
        run_case(30, 10, 5, 3, 0, 30, 4, -1, -1);
        // No resonance in range: timeout path (R7).
        run_case(25, 22, 4, 2, 5, 10, 9, -1, -1);
        // Short glitch rejected (R4) and mid-search start ignored (R2).
        run_case(50, 30, 8, 4, 7, 40, 17, 5, 20);

        // Abort by enable low (R9).
        @(negedge clk);
        code_hi = 8'd60; code_lo = 8'd10; step_div = 8'd2; res_code = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 inj_en off after abort", int'(inj_en), 0);
        chk("R9 main_en off after abort", int'(main_en), 0);
        chk("R9 code back to code_hi", int'(freq_code), 60);
        chk("R9 flags clear", int'({hold, timeout, done_pulse}), 0);
        en = 1'b1;
        @(negedge clk);
        chk("R1 idle holds after abort", int'(inj_en), 0);

        // A full run still works after the abort.
        run_case(60, 10, 3, 1, 2, 58, 5, -1, -1);
        chk("R5 scoreboard drained", sb.size(), 0);
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule